// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the read and write cycles of a simple 8-bit processor bus. The low address byte and the data byte share the same pins. A core-side request carries the address, the write data, a read/write flag and a memory-or-I/O flag. The request is accepted only while the sequencer is idle.

Each cycle has three phases. In T1 the full address goes out and an address-latch pulse marks the low byte so that external logic can latch it. In T2 the read or write strobe goes low, and a READY input is sampled on the falling clock edge in the middle of the phase. In T3 the data moves, and the strobe is released on the edge that ends T3. While READY is found low, wait clocks are inserted between T2 and T3, and every bus output is held frozen during them.

The block also drives a race-free, active-low enable for the data buffer, and four decoded strobes for memory read, memory write, I/O read and I/O write. Read data is captured from the shared bus and handed back to the core together with a one-clock done pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: A cycle found ready on its first sample takes exactly three clocks. `ale` is high for exactly the first clock (T1). The active strobe (`rd_n` for a read, `wr_n` for a write) is low for the second and third clocks and never while `ale` is high. Both strobes are high again on the clock after T3.
- R2: READY is sampled only on the falling clock edge inside T2 and inside each wait clock. A change of `ready` after that falling edge has no effect on the current clock, and a change before it does.
- R3: Each falling-edge sample that finds `ready` low adds exactly one wait clock after T2. During a wait clock every bus output (`ale`, `io_m`, `s1`, `rd_n`, `wr_n`, `ad_out`, `ad_oe`, `addr_hi`, `den_n`, the four decoded strobes) equals its value in T2.
- R4: `io_m` is 1 for an I/O transfer and 0 for a memory transfer, held from T1 through T3.
- R5: The decoded strobes are active-low and at most one is low at a time. During the strobe phases the one selected by index {io,write} is low: 0 = `memr_n`, 1 = `memw_n`, 2 = `ior_n`, 3 = `iow_n`.
- R6: In T1, `ad_oe` is 1 and `ad_out` carries the low address byte. `addr_hi` carries the upper address byte from T1 through T3.
- R7: For a write, `ad_out` carries the write data with `ad_oe` = 1 from T2 through T3. For a read, `ad_oe` is 0 from T2 on.
- R8: `den_n` is 1 when idle. During a read it equals `rd_n` while `ale` is low and is 1 while `ale` is high. During a write it equals `ale`.
- R9: `s1` is 1 for a read and 0 for a write, and it holds steady from T1 through T3, wait clocks included.
- R10: Read data is taken from `ad_in` on the clock edge that ends T3. It appears on `rdata` in the clock after T3, together with `done` = 1 for exactly one clock.
- R11: Synchronous active-high reset, including in the middle of a cycle, returns the sequencer to idle: `busy` = 0, `done` = 0, `ale` = 0, both strobes high, `ad_oe` = 0, `den_n` = 1.
- R12: A request presented while `busy` = 1 is ignored. The running cycle keeps its own address, and no new cycle starts from that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a cycle (taken only when idle) |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O, 0 = memory |
| ready | input | 1 | Bus ready, sampled on falling edges |
| ad_in | input | DW | Shared address/data lines, input side |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | 1 = I/O, 0 = memory |
| s1 | output | 1 | 1 = read, 0 = write |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | DW | Shared address/data lines, output side |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_hi | output | AW-DW | Upper address byte |
| den_n | output | 1 | Data buffer enable, active low |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |

## Verification
The bench moves `ready` just before and just after the falling edge inside T2. A design that sampled READY on the rising edge would add a wait it should skip, or skip one it should add. Runs with zero, one and three wait clocks compare every output against its T2 value; a sequencer that let the lines drift, or that counted waits off by one, shows a changed output or a strobe of the wrong length. The read data on `ad_in` is swapped at the start of T3, so capturing one edge early returns the stale value. Other tests cover a reset that arrives in the middle of a wait and a request held high while the sequencer is busy, which catch a strobe left active and a restart on the second address.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4
  } cyc_state_t;

  // strobe phases: T2, wait clocks and T3
  function automatic logic in_xfer(input cyc_state_t s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       ready,
  output logic       accept,
  output cyc_state_t st
);
  cyc_state_t st_nxt;
  logic       rdy_q;

  assign accept = req && (st == ST_IDLE);

  // READY is caught mid-phase, on the falling edge
  always_ff @(negedge clk) begin
    if (rst)
      rdy_q <= 1'b0;
    else if ((st == ST_T2) || (st == ST_TW))
      rdy_q <= ready;
  end

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (accept) st_nxt = ST_T1;
      ST_T1:   st_nxt = ST_T2;
      ST_T2,
      ST_TW:   st_nxt = rdy_q ? ST_T3 : ST_TW;
      ST_T3:   st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  AST_T1_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T1) |=> (st == ST_T2)); // R1
  AST_T3_ENDS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T3) |=> (st == ST_IDLE)); // R1
endmodule

// File: rtl/bus_seq_datapath.sv
module bus_seq_datapath
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  cyc_state_t    st,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [DW-1:0] ad_in,
  output logic          write_q,
  output logic          io_q,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] addr_hi,
  output logic [DW-1:0] rdata,
  output logic          done
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      io_q    <= req_io;
    end
  end

  // read data taken on the edge that closes T3
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= (st == ST_T3);
      if ((st == ST_T3) && !write_q) rdata <= ad_in;
    end
  end

  assign ad_out  = (st == ST_T1) ? addr_q[DW-1:0] : wdata_q;
  assign ad_oe   = (st == ST_T1) || (write_q && in_xfer(st));
  assign addr_hi = addr_q[AW-1:DW];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    in_xfer(st) |-> $stable(addr_hi)); // R6
endmodule

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
  import bus_seq_pkg::*;
(
  input  cyc_state_t st,
  input  logic       write_q,
  input  logic       io_q,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       io_m,
  output logic       s1,
  output logic       den_n,
  output logic [3:0] strb_n
);
  logic xfer;
  assign xfer  = in_xfer(st);
  assign ale   = (st == ST_T1);
  assign rd_n  = !(xfer && !write_q);
  assign wr_n  = !(xfer && write_q);
  assign io_m  = io_q;
  assign s1    = !write_q;

  // read: strobe gated by ALE low; write: follows ALE
  always_comb begin
    if (st == ST_IDLE)  den_n = 1'b1;
    else if (s1)        den_n = ale ? 1'b1 : rd_n;
    else                den_n = ale;
  end

  // index {io,write}: 0 mem rd, 1 mem wr, 2 io rd, 3 io wr
  for (genvar k = 0; k < 4; k++) begin : g_strb
    localparam int KIO = k / 2;
    localparam int KWR = k % 2;
    assign strb_n[k] = !(xfer && (io_q == KIO[0]) && (write_q == KWR[0]));
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0(~strb_n)); // R5
    AST_NO_ALE_WITH_STROBE: assert (!(ale && !(rd_n && wr_n))); // R1
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          io_m,
  output logic          s1,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] addr_hi,
  output logic          den_n,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n
);
  cyc_state_t st;
  logic       accept;
  logic       write_q;
  logic       io_q;
  logic [3:0] strb_n;

  bus_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .req(req), .ready(ready),
    .accept(accept), .st(st)
  );

  bus_seq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .st(st),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_io(req_io), .ad_in(ad_in),
    .write_q(write_q), .io_q(io_q), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .rdata(rdata), .done(done)
  );

  bus_seq_decode u_dec (
    .st(st), .write_q(write_q), .io_q(io_q),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1),
    .den_n(den_n), .strb_n(strb_n)
  );

  assign busy   = (st != ST_IDLE);
  assign memr_n = strb_n[0];
  assign memw_n = strb_n[1];
  assign ior_n  = strb_n[2];
  assign iow_n  = strb_n[3];

  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TW) |-> $stable({ale, io_m, s1, rd_n, wr_n, ad_out, ad_oe,
                               addr_hi, den_n, strb_n})); // R3
  AST_S1_STEADY: assert property (@(posedge clk) disable iff (rst)
    in_xfer(st) |-> ($stable(s1) && $stable(io_m))); // R9
  AST_IDLE_DEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !busy |-> den_n); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && !ad_oe && !busy)); // R11
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic        ready = 1'b1;
  logic [7:0]  ad_in = '0;
  logic        busy, done, ale, io_m, s1, rd_n, wr_n, ad_oe, den_n;
  logic        memr_n, memw_n, ior_n, iow_n;
  logic [7:0]  rdata, ad_out, addr_hi;

  int checks = 0;
  int errors = 0;

  bus_cycle_seq dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .ready(ready), .ad_in(ad_in), .busy(busy), .done(done), .rdata(rdata),
    .ale(ale), .io_m(io_m), .s1(s1), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .den_n(den_n),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // move to 15 ns after the next rising edge (past the falling edge)
  task automatic step();
    @(posedge clk);
    #15;
  endtask

  function automatic logic [31:0] snap();
    return {ale, io_m, s1, rd_n, wr_n, ad_out, ad_oe, addr_hi, den_n,
            memr_n, memw_n, ior_n, iow_n};
  endfunction

  task automatic run_cycle(input bit wr, input bit io, input logic [15:0] a,
                           input logic [7:0] wd, input int waits,
                           input logic [7:0] rdv);
    logic [31:0] s2;
    logic [3:0]  exp_strb;
    exp_strb = ~(4'b0001 << {io, wr});
    req = 1'b1; req_addr = a; req_wdata = wd; req_write = wr; req_io = io;
    ad_in = ~rdv;
    ready = (waits == 0);
    step(); // T1
    req = 1'b0;
    chk(ale == 1'b1 && rd_n && wr_n, "R1", "T1 ale/strobes", {ale, rd_n, wr_n}, 3'b111);
    chk(ad_oe && ad_out == a[7:0], "R6", "T1 low address", ad_out, a[7:0]);
    chk(addr_hi == a[15:8], "R6", "T1 high address", addr_hi, a[15:8]);
    chk(io_m == io, "R4", "io_m", io_m, io);
    chk(s1 == !wr, "R9", "s1", s1, !wr);
    chk(den_n == 1'b1, "R8", "den_n in T1", den_n, 1);
    step(); // T2
    chk(!ale && rd_n == wr && wr_n == !wr, "R1", "T2 strobe", {ale, rd_n, wr_n}, {1'b0, wr, !wr});
    chk({iow_n, ior_n, memw_n, memr_n} == exp_strb, "R5", "decoded strobes",
        {iow_n, ior_n, memw_n, memr_n}, exp_strb);
    chk(ad_oe == wr, "R7", "T2 ad_oe", ad_oe, wr);
    if (wr) chk(ad_out == wd, "R7", "write data", ad_out, wd);
    chk(den_n == 1'b0, "R8", "den_n in T2", den_n, 0);
    s2 = snap();
    for (int i = 0; i < waits; i++) begin
      ready = (i + 1 < waits) ? 1'b0 : 1'b1;
      step(); // wait clock
      chk(snap() == s2 && busy, "R3", "frozen wait clock", snap(), s2);
    end
    ready = 1'b1;
    step(); // T3
    chk(snap() == s2, "R1", "T3 strobe held", snap(), s2);
    ad_in = rdv;
    step(); // idle
    ad_in = 8'h00;
    chk(rd_n && wr_n && !ad_oe && !busy, "R1", "released after T3",
        {rd_n, wr_n, ad_oe, busy}, 4'b1100);
    chk(done == 1'b1, "R10", "done pulse", done, 1);
    if (!wr) chk(rdata == rdv, "R10", "read data", rdata, rdv);
    chk(den_n == 1'b1, "R8", "den_n idle", den_n, 1);
    step();
    chk(done == 1'b0, "R10", "done one clock", done, 0);
  endtask

  // ready changes around the T2 falling edge
  task automatic ready_edge(input bit low_before);
    req = 1'b1; req_addr = 16'h2233; req_write = 1'b0; req_io = 1'b0;
    ready = 1'b1;
    step(); // T1
    req = 1'b0;
    @(posedge clk); // into T2
    #3 ready = low_before ? 1'b0 : 1'b1;
    #10 ready = low_before ? 1'b1 : 1'b0; // after the falling edge
    #2;
    step(); // T3 or wait clock
    chk(rd_n == 1'b0, "R2", "strobe still low", rd_n, 0);
    ready = 1'b1;
    step();
    if (low_before) begin
      chk(!done && !rd_n, "R2", "one wait from low sample", {done, rd_n}, 2'b00);
      step();
    end
    chk(done == 1'b1, "R2", "completion clock", done, 1);
    step();
  endtask

  task automatic busy_ignore();
    req = 1'b1; req_addr = 16'h1234; req_write = 1'b0; req_io = 1'b1;
    ready = 1'b1;
    step(); // T1
    req_addr = 16'hABCD; // request stays up while busy
    step(); // T2
    chk(addr_hi == 8'h12, "R12", "address kept", addr_hi, 8'h12);
    step(); // T3
    req = 1'b0;
    chk(addr_hi == 8'h12, "R12", "address kept T3", addr_hi, 8'h12);
    step(); // idle, done
    step();
    chk(!busy && !ale, "R12", "no restart", {busy, ale}, 2'b00);
  endtask

  task automatic mid_reset();
    req = 1'b1; req_addr = 16'h0F0F; req_write = 1'b1; req_io = 1'b0;
    ready = 1'b0;
    step(); // T1
    req = 1'b0;
    step(); // T2
    step(); // wait
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe && den_n, "R11",
        "mid-cycle reset", {busy, done, ale, rd_n, wr_n, ad_oe, den_n}, 7'b0001101);
    ready = 1'b1;
    step();
    chk(!busy, "R11", "stays idle", busy, 0);
  endtask

  initial begin
    step(); step();
    chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe && den_n, "R11",
        "reset state", {busy, done, ale, rd_n, wr_n, ad_oe, den_n}, 7'b0001101);
    rst = 1'b0;
    step();
    run_cycle(1'b0, 1'b0, 16'h12A5, 8'h00, 0, 8'h5C); // mem read
    run_cycle(1'b1, 1'b0, 16'hBEEF, 8'h3C, 0, 8'h00); // mem write
    run_cycle(1'b0, 1'b1, 16'h0081, 8'h00, 1, 8'hE7); // io read, 1 wait
    run_cycle(1'b1, 1'b1, 16'h7F42, 8'hA9, 3, 8'h00); // io write, 3 waits
    run_cycle(1'b0, 1'b0, 16'hFFFF, 8'h00, 2, 8'h01);
    ready_edge(1'b0);
    ready_edge(1'b1);
    busy_ignore();
    mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule